// File: doc/BRIEF.md
# Frequency Offset Tracker

This block sits after the frequency discriminator of a digital FSK receiver and removes the carrier frequency error between the transmitter and receiver. Each valid discriminator sample is signed. The block treats the running centre of these samples as the carrier offset and tracks it with a first-order loop. The loop is a leaky accumulator with extra fractional bits. On each accepted sample it moves toward the sample by a power-of-two fraction of the error, so no multiplier is needed.

The loop gain has two settings. One applies before the packet's sync word has been found and the other applies after it. The estimate is clamped to a programmable fraction of the channel bandwidth. The loop can be held frozen until carrier sense is raised, which stops it from wandering off on noise. For amplitude-keyed traffic the loop is switched off entirely. Each incoming sample, less the current estimate, is sent out one cycle later. The estimate itself is always visible on a status output.

Top module: `fo_track`

## Requirements
- R1: After reset, `est_out` is 0 and `out_vld` is 0.
- R2: When `smp_vld` is 1, the next cycle shows `out_vld`=1 and `out_smp` = smp_in − E, saturated to [−128, 127]. E is the estimate as it stood before that edge, or 0 in amplitude mode. When `smp_vld` is 0, the next cycle shows `out_vld`=0.
- R3: An accepted sample updates the accumulator A (16-bit signed, 8 fractional bits) to A + ((smp_in·256 − A) >>> (3 + g)), using an arithmetic shift. g is `cfg_gain_post` if `sync_found` is 1 on that sample, otherwise `cfg_gain_pre`.
- R4: `est_out` equals A >>> 8, which is the top 8 bits of the accumulator.
- R5: Every update clamps A to ±L·256. L is 0 for `cfg_limit`=0 (tracking off, estimate stays 0), chan_bw>>3 for code 1, chan_bw>>2 for code 2 and chan_bw>>1 for code 3.
- R6: While `cfg_cs_gate`=1 and `carrier_sense`=0, valid samples do not change the estimate. Correction still uses the held estimate.
- R7: `mod_sel` encodes 2'b00 2-FSK, 2'b01 GFSK, 2'b10 amplitude-keyed and 2'b11 MSK. In amplitude-keyed mode the accumulator is forced to 0 on every edge, and samples pass through uncorrected.
- R8: `clr`=1 sets the accumulator to 0 at the next edge. This takes priority over any update on the same sample.
- R9: Cycles with `smp_vld`=0 leave the estimate unchanged, whatever `smp_in` and `sync_found` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of the estimate |
| smp_vld | input | 1 | Discriminator sample valid strobe |
| smp_in | input | 8 | Signed instantaneous-frequency sample |
| carrier_sense | input | 1 | Carrier present flag |
| sync_found | input | 1 | Sync word detected flag, sampled on valid samples |
| mod_sel | input | 2 | Modulation type code (see R7) |
| cfg_limit | input | 2 | Tracking range code (see R5) |
| cfg_gain_pre | input | 2 | Loop gain shift code before sync |
| cfg_gain_post | input | 2 | Loop gain shift code after sync |
| cfg_cs_gate | input | 1 | Freeze loop until carrier sense when 1 |
| chan_bw | input | 8 | Channel bandwidth in discriminator units |
| est_out | output | 8 | Signed offset estimate (status) |
| out_smp | output | 8 | Offset-corrected sample, registered |
| out_vld | output | 1 | Valid strobe for out_smp |

## Verification
The hardest state to reach is the clamp boundary. Here the accumulator sits exactly at ±L·256, and further samples keep trying to push it past that value with different gains on each side of the sync flag. The bench gets there by clearing the loop and then feeding long runs of a constant sample. Those runs start before sync and continue after it. The sweep covers every limit code and several gain pairs, and the target values lie both inside and outside the limit, so the loop has to settle on the clamp or below it. Short bursts then flip the gate, the modulation type and the clear against a loop that is already off zero.

// File: rtl/fo_pkg.sv
package fo_pkg;

   typedef enum logic [1:0] {
      MOD_FSK2 = 2'b00,
      MOD_GFSK = 2'b01,
      MOD_AMP  = 2'b10,
      MOD_MSK  = 2'b11
   } mod_e;

   function automatic logic mod_is_amp(input logic [1:0] code);
      return code == MOD_AMP;
   endfunction

endpackage

// File: rtl/fo_limit.sv
module fo_limit #(
   parameter int BW_W   = 8,
   parameter int FRAC_W = 8,
   parameter int ERR_W  = 18
) (
   input  logic [1:0]              code,
   input  logic [BW_W-1:0]         bw,
   output logic signed [ERR_W-1:0] lim_pos
);

   logic [BW_W-1:0] lim_est;
   logic [2:0]      div_sh;

   always_comb begin
      div_sh  = 3'd4 - {1'b0, code};
      lim_est = (code == 2'd0) ? '0 : (bw >> div_sh);
      lim_pos = $signed(ERR_W'({lim_est, {FRAC_W{1'b0}}}));
   end

endmodule

// File: rtl/fo_loop.sv
module fo_loop #(
   parameter int SMP_W     = 8,
   parameter int FRAC_W    = 8,
   parameter int GAIN_BASE = 3,
   parameter int ACC_W     = SMP_W + FRAC_W,
   parameter int ERR_W     = ACC_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    amp,
   input  logic                    upd,
   input  logic signed [SMP_W-1:0] smp,
   input  logic [1:0]              gain_code,
   input  logic signed [ERR_W-1:0] lim_pos,
   output logic signed [ACC_W-1:0] acc
);

   logic signed [ERR_W-1:0] smp_ext, acc_ext, err, step, sum, neg_lim, clamped;
   logic [3:0]              sh;

   always_comb begin
      smp_ext = {{2{smp[SMP_W-1]}}, smp, {FRAC_W{1'b0}}};
      acc_ext = {{2{acc[ACC_W-1]}}, acc};
      sh      = 4'(GAIN_BASE) + {2'b00, gain_code};
      err     = smp_ext - acc_ext;
      step    = err >>> sh;
      sum     = acc_ext + step;
      neg_lim = -lim_pos;
      if (sum > lim_pos)
         clamped = lim_pos;
      else if (sum < neg_lim)
         clamped = neg_lim;
      else
         clamped = sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (clr || amp)
         acc <= '0;
      else if (upd)
         acc <= ACC_W'(clamped);
   end

endmodule

// File: rtl/fo_correct.sv
module fo_correct #(
   parameter int SMP_W   = 8,
   parameter bit OUT_SAT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld,
   input  logic signed [SMP_W-1:0] smp,
   input  logic signed [SMP_W-1:0] est,
   output logic signed [SMP_W-1:0] out_smp,
   output logic                    out_vld
);

   localparam logic signed [SMP_W-1:0] MAX_V = {1'b0, {(SMP_W-1){1'b1}}};
   localparam logic signed [SMP_W-1:0] MIN_V = {1'b1, {(SMP_W-1){1'b0}}};

   logic signed [SMP_W:0]   diff;
   logic signed [SMP_W-1:0] res;

   assign diff = {smp[SMP_W-1], smp} - {est[SMP_W-1], est};

   generate
      if (OUT_SAT) begin : g_sat
         always_comb begin
            if (diff[SMP_W] != diff[SMP_W-1])
               res = diff[SMP_W] ? MIN_V : MAX_V;
            else
               res = diff[SMP_W-1:0];
         end
      end else begin : g_wrap
         always_comb res = SMP_W'(diff);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_smp <= '0;
      end else begin
         out_vld <= vld;
         if (vld)
            out_smp <= res;
      end
   end

endmodule

// File: rtl/fo_track.sv
module fo_track #(
   parameter int SMP_W     = 8,
   parameter int FRAC_W    = 8,
   parameter int GAIN_BASE = 3,
   parameter bit OUT_SAT   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    smp_vld,
   input  logic signed [SMP_W-1:0] smp_in,
   input  logic                    carrier_sense,
   input  logic                    sync_found,
   input  logic [1:0]              mod_sel,
   input  logic [1:0]              cfg_limit,
   input  logic [1:0]              cfg_gain_pre,
   input  logic [1:0]              cfg_gain_post,
   input  logic                    cfg_cs_gate,
   input  logic [SMP_W-1:0]        chan_bw,
   output logic signed [SMP_W-1:0] est_out,
   output logic signed [SMP_W-1:0] out_smp,
   output logic                    out_vld
);

   localparam int ACC_W = SMP_W + FRAC_W;
   localparam int ERR_W = ACC_W + 2;

   generate
      if (SMP_W < 4) begin : g_bad_smp
         $error("fo_track: SMP_W must be at least 4");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fo_track: FRAC_W must be at least 2");
      end
      if (GAIN_BASE < 0 || GAIN_BASE > 12) begin : g_bad_gain
         $error("fo_track: GAIN_BASE out of range");
      end
   endgenerate

   logic                    amp, frozen, upd;
   logic [1:0]              gain_code;
   logic signed [ERR_W-1:0] lim_pos;
   logic signed [ACC_W-1:0] acc;
   logic signed [SMP_W-1:0] est_used;

   always_comb begin
      amp       = fo_pkg::mod_is_amp(mod_sel);
      frozen    = cfg_cs_gate && !carrier_sense;
      upd       = smp_vld && !frozen;
      gain_code = sync_found ? cfg_gain_post : cfg_gain_pre;
      est_out   = acc[ACC_W-1:FRAC_W];
      est_used  = amp ? '0 : est_out;
   end

   fo_limit #(.BW_W(SMP_W), .FRAC_W(FRAC_W), .ERR_W(ERR_W)) u_limit (
      .code    (cfg_limit),
      .bw      (chan_bw),
      .lim_pos (lim_pos)
   );

   fo_loop #(.SMP_W(SMP_W), .FRAC_W(FRAC_W), .GAIN_BASE(GAIN_BASE),
             .ACC_W(ACC_W), .ERR_W(ERR_W)) u_loop (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .amp       (amp),
      .upd       (upd),
      .smp       (smp_in),
      .gain_code (gain_code),
      .lim_pos   (lim_pos),
      .acc       (acc)
   );

   fo_correct #(.SMP_W(SMP_W), .OUT_SAT(OUT_SAT)) u_correct (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (smp_vld),
      .smp     (smp_in),
      .est     (est_used),
      .out_smp (out_smp),
      .out_vld (out_vld)
   );

endmodule

// File: rtl/fo_track_chk.sv
module fo_track_chk #(
   parameter int SMP_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    clr,
   input logic                    smp_vld,
   input logic signed [SMP_W-1:0] smp_in,
   input logic                    carrier_sense,
   input logic [1:0]              mod_sel,
   input logic [1:0]              cfg_limit,
   input logic                    cfg_cs_gate,
   input logic [SMP_W-1:0]        chan_bw,
   input logic signed [SMP_W-1:0] est_out,
   input logic signed [SMP_W-1:0] out_smp,
   input logic                    out_vld
);

   logic amp_c, frz_c, live_c;
   int   lim_c, est_c;

   always_comb begin
      amp_c  = (mod_sel == 2'b10);
      frz_c  = cfg_cs_gate && !carrier_sense;
      live_c = !clr && !amp_c;
      lim_c  = (cfg_limit == 2'd0) ? 0 : int'(chan_bw >> (3'd4 - {1'b0, cfg_limit}));
      est_c  = int'(est_out);
   end

   // R2
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> out_vld);
   // R2
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> !out_vld);
   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> est_out == '0);
   // R7
   amp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      amp_c |=> est_out == '0);
   // R7
   amp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (amp_c && smp_vld) |=> out_smp == $past(smp_in));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && live_c) |=> $stable(est_out));
   // R6
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_c && live_c) |=> $stable(est_out));
   // R5
   limit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !frz_c && live_c) |=> (est_c <= $past(lim_c) && est_c >= -$past(lim_c)));

endmodule

bind fo_track fo_track_chk #(.SMP_W(SMP_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .clr           (clr),
   .smp_vld       (smp_vld),
   .smp_in        (smp_in),
   .carrier_sense (carrier_sense),
   .mod_sel       (mod_sel),
   .cfg_limit     (cfg_limit),
   .cfg_cs_gate   (cfg_cs_gate),
   .chan_bw       (chan_bw),
   .est_out       (est_out),
   .out_smp       (out_smp),
   .out_vld       (out_vld)
);

// File: tb/fo_track_tb.sv
module fo_track_tb;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr = 1'b0;
   logic              smp_vld = 1'b0;
   logic signed [7:0] smp_in = '0;
   logic              carrier_sense = 1'b0;
   logic              sync_found = 1'b0;
   logic [1:0]        mod_sel = 2'b00;
   logic [1:0]        cfg_limit = 2'd3;
   logic [1:0]        cfg_gain_pre = 2'd0;
   logic [1:0]        cfg_gain_post = 2'd0;
   logic              cfg_cs_gate = 1'b0;
   logic [7:0]        chan_bw = 8'd200;
   logic signed [7:0] est_out, out_smp;
   logic              out_vld;

   int total = 0;
   int bad   = 0;
   int m_acc = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   fo_track u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld), .smp_in(smp_in),
      .carrier_sense(carrier_sense), .sync_found(sync_found), .mod_sel(mod_sel),
      .cfg_limit(cfg_limit), .cfg_gain_pre(cfg_gain_pre), .cfg_gain_post(cfg_gain_post),
      .cfg_cs_gate(cfg_cs_gate), .chan_bw(chan_bw), .est_out(est_out),
      .out_smp(out_smp), .out_vld(out_vld)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sat8(input int v);
      if (v > 127) return 127;
      if (v < -128) return -128;
      return v;
   endfunction

   // one sample step: drive at negedge, check after the next rising edge
   task automatic step(input int v, input bit vld, input bit syn, input bit cs,
                       input bit c, input string req);
      int est_b, used, exp_o, sh, e, n, lim;
      bit amp;
      smp_in = 8'(v); smp_vld = vld; sync_found = syn; carrier_sense = cs; clr = c;
      amp   = (mod_sel == 2'b10);
      est_b = m_acc >>> 8;
      used  = amp ? 0 : est_b;
      exp_o = sat8(v - used);
      if (c || amp) m_acc = 0;
      else if (vld && !(cfg_cs_gate && !cs)) begin
         sh  = 3 + (syn ? int'(cfg_gain_post) : int'(cfg_gain_pre));
         e   = v * 256 - m_acc;
         n   = m_acc + (e >>> sh);
         lim = (cfg_limit == 0) ? 0 : (int'(chan_bw) >> (4 - int'(cfg_limit))) * 256;
         if (n > lim) n = lim;
         if (n < -lim) n = -lim;
         m_acc = n;
      end
      @(posedge clk); #2;
      chk(out_vld == vld, {req, " R2 out_vld"}, int'(out_vld), int'(vld));
      if (vld) chk(int'(out_smp) == exp_o, {req, " R2 out_smp"}, int'(out_smp), exp_o);
      chk(int'(est_out) == (m_acc >>> 8), {req, " R4 est"}, int'(est_out), m_acc >>> 8);
      @(negedge clk);
   endtask

   initial begin
      repeat (500000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(est_out == 0, "R1 est", int'(est_out), 0);
      chk(out_vld == 0, "R1 vld", int'(out_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R5 sweep: limits x gains x targets, sync toggles mid-run
      for (int l = 0; l < 4; l++)
         for (int gp = 0; gp < 4; gp++)
            for (int gq = 0; gq < 4; gq += 3)
               for (int t = 0; t < 4; t++) begin
                  int tv;
                  tv = (t == 0) ? -100 : (t == 1) ? -37 : (t == 2) ? 45 : 120;
                  cfg_limit = 2'(l); cfg_gain_pre = 2'(gp); cfg_gain_post = 2'(gq);
                  step(0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
                  for (int k = 0; k < 24; k++)
                     step(tv + (k % 3) - 1, 1'b1, k >= 12, 1'b1, 1'b0, "R3 R5");
               end

      // R5 limit at the clamp with a small bandwidth
      cfg_limit = 2'd1; chan_bw = 8'd37; cfg_gain_pre = 2'd0;
      for (int k = 0; k < 30; k++) step(-90, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
      chk(int'(est_out) == -4, "R5 clamp", int'(est_out), -4);
      chan_bw = 8'd200; cfg_limit = 2'd3;

      // R9 idle cycles with changing data and sync
      for (int k = 0; k < 10; k++) step(127 - k * 25, 1'b0, k[0], 1'b1, 1'b0, "R9");

      // R6 gate closed then opened
      cfg_cs_gate = 1'b1;
      for (int k = 0; k < 12; k++) step(-120, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
      for (int k = 0; k < 12; k++) step(-120, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
      for (int k = 0; k < 6; k++) step(100, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
      cfg_cs_gate = 1'b0;

      // R2 saturation at both ends
      for (int k = 0; k < 30; k++) step(-120, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
      step(127, 1'b1, 1'b0, 1'b1, 1'b0, "R2 sat hi");
      for (int k = 0; k < 30; k++) step(110, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
      step(-128, 1'b1, 1'b0, 1'b1, 1'b0, "R2 sat lo");

      // R7 amplitude mode with a nonzero estimate, then other codes
      mod_sel = 2'b10;
      for (int k = 0; k < 8; k++) step(-128 + k * 33, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
      for (int m = 0; m < 4; m++) begin
         mod_sel = 2'(m);
         if (m != 2)
            for (int k = 0; k < 8; k++) step(60 - m * 40, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
      end

      // R8 clear wins over a valid update
      for (int k = 0; k < 10; k++) step(90, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
      step(90, 1'b1, 1'b1, 1'b1, 1'b1, "R8 clr");
      chk(est_out == 0, "R8 clr", int'(est_out), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule